// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against a stalled program. A 32-bit counter advances on strobes from one of four clock-enable inputs. When a chosen bit of that counter rises, the block does one of two things. In watchdog mode it issues a one-cycle reset request. In interval mode it raises a sticky interrupt flag. Software must keep clearing the counter before the chosen bit rises, or the watchdog fires.

All settings live in one 16-bit control register on a simple bus. A write changes the register only when both byte lanes are enabled and the upper byte carries the unlock key 0x5A. A full-width write with any other key value triggers a reset request. So does a write that enables only one byte lane. After a reset request, the register, the counter and the interrupt flag all go back to their reset values.

Top module: `guard_timer`

## Requirements
- R1: After the synchronous reset, a read of the control register returns 0x6904, and `rst_req` and `irq_out` are low.
- R2: A read with `bus_re` high selects an address. The data appears on `bus_rdata` one cycle later. At the control address, bits 15:8 are always 0x69, bit 3 is always 0, and the other bits show the current fields. Any other address reads as 0.
- R3: A write is accepted when it targets the control address, enables both byte lanes (`bus_be` = 11) and carries 0x5A in bits 15:8. The low byte then loads the fields: hold (bit 7), source select (bits 6:5), mode (bit 4), counter clear (bit 3) and tap code (bits 2:0).
- R4: A full-width write to the control address whose upper byte is not 0x5A changes no field. In the next cycle it raises `rst_req`.
- R5: A write to the control address with exactly one byte lane enabled raises `rst_req` in the next cycle, whatever its key. A write with no lane enabled is ignored.
- R6: Writes to any address other than the control address have no effect and raise no reset request.
- R7: `rst_req` lasts exactly one cycle. At the end of that cycle, the fields, the counter and the interrupt flag return to their reset values. A bus write made during that cycle is discarded.
- R8: The counter advances only when the strobe selected by the source field is high: `tick_src[0]` for 00, `tick_src[1]` for 01, `tick_src[2]` for 10 and `tick_src[3]` for 11.
- R9: While the hold bit is 1, the counter does not advance.
- R10: An accepted write with bit 3 set loads the counter with zero.
- R11: Tap codes 000 to 111 select counter bits 31, 27, 23, 19, 15, 13, 9 and 6. Expiry happens on the advance that moves the selected bit from 0 to 1. Counting from zero with tap bit N, that is the 2^N-th advance.
- R12: In watchdog mode (mode bit 0), `rst_req` is asserted in the second cycle after the expiring advance.
- R13: In interval mode (mode bit 1), expiry sets a sticky flag that drives `irq_out`, and no reset request is made. The counter keeps counting, so the tap bit rises again 2^(N+1) advances later.
- R14: `irq_ack` clears the interrupt flag. If a new expiry and an acknowledge arrive in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte-lane enables, bit 1 for bits 15:8 |
| bus_rdata | output | 16 | Registered read data |
| tick_src | input | 4 | Four one-cycle clock-enable strobes |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_out | output | 1 | Interval-mode interrupt flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter cannot be read, so the hardest behaviours to show are the ones inside it: ignored strobes, hold, clear, and the counter continuing to run after an interval expiry. Each is shown by timing instead. The bench drives an exact number of strobes and checks that expiry lands on precisely the 2^N-th counted advance. If the counter had moved when it should not have, expiry would come early. If the counter had restarted after an interval expiry, a second expiry would appear inside a window where none is allowed. To reach the long default tap, the bench holds a strobe high for 32768 consecutive cycles.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int TAP_W  = 3;

  localparam logic [7:0] KEY_WRITE = 8'h5A;
  localparam logic [7:0] KEY_READ  = 8'h69;

  localparam int HOLD_BIT = 7;
  localparam int SRC_LSB  = 5;
  localparam int MODE_BIT = 4;
  localparam int ZERO_BIT = 3;

  typedef struct packed {
    logic             hold;
    logic [SEL_W-1:0] src;
    logic             mode;   // 0: watchdog, 1: interval
    logic [TAP_W-1:0] tap;
  } cfg_t;

  localparam cfg_t CFG_RST = '{hold: 1'b0, src: '0, mode: 1'b0, tap: 3'b100};

  function automatic logic [4:0] tap_bit(input logic [TAP_W-1:0] code);
    logic [4:0] b;
    case (code)
      3'd0:    b = 5'd31;
      3'd1:    b = 5'd27;
      3'd2:    b = 5'd23;
      3'd3:    b = 5'd19;
      3'd4:    b = 5'd15;
      3'd5:    b = 5'd13;
      3'd6:    b = 5'd9;
      default: b = 5'd6;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/gt_ctrl_reg.sv
module gt_ctrl_reg
  import guard_timer_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              hit,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              wr_ok,
  output logic              bad_wr,
  output logic              zero_cnt
);

  logic full_w;
  logic any_w;

  assign full_w   = &be;
  assign any_w    = |be;
  assign wr_ok    = hit && full_w && (wdata[DATA_W-1:DATA_W-8] == KEY_WRITE);
  assign bad_wr   = hit && any_w && !wr_ok;
  assign zero_cnt = wr_ok && wdata[ZERO_BIT];

  always_ff @(posedge clk) begin
    if (clr) begin
      cfg <= CFG_RST;
    end else if (wr_ok) begin
      cfg.hold <= wdata[HOLD_BIT];
      cfg.src  <= wdata[SRC_LSB +: SEL_W];
      cfg.mode <= wdata[MODE_BIT];
      cfg.tap  <= wdata[TAP_W-1:0];
    end
  end

endmodule

// File: rtl/gt_tick_sel.sv
module gt_tick_sel
  import guard_timer_pkg::*;
#(
  parameter int NS = SRC_N
) (
  input  logic [NS-1:0]    strobes,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  output logic             advance
);

  logic [NS-1:0] hit;

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign hit[i] = strobes[i] && (sel == SEL_W'(i));
  end

  assign advance = (|hit) && !hold;

endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import guard_timer_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             zero,
  input  logic             advance,
  input  logic             restart,
  input  logic [TAP_W-1:0] tap,
  output logic [CW-1:0]    cnt,
  output logic             expired
);

  localparam int IW = $clog2(CW);

  logic [CW-1:0] nxt;
  logic [IW-1:0] idx;
  logic          edge_hit;

  assign nxt      = cnt + CW'(1);
  assign idx      = IW'(tap_bit(tap));
  assign edge_hit = advance && !cnt[idx] && nxt[idx];

  always_ff @(posedge clk) begin
    if (clr || zero) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= edge_hit;
      if (advance) begin
        cnt <= (edge_hit && restart) ? '0 : nxt;
      end
    end
  end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter int                CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  tick_src,
  input  logic              irq_ack,
  output logic              irq_out,
  output logic              rst_req
);

  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             soft_clr;
  logic             wr_hit;
  logic             wr_ok;
  logic             bad_wr;
  logic             zero_cnt;
  logic             advance;

  assign soft_clr = rst || rst_req;
  assign wr_hit   = bus_we && (bus_addr == CTRL_ADDR);

  gt_ctrl_reg u_reg (
    .clk      (clk),
    .clr      (soft_clr),
    .hit      (wr_hit),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .cfg      (cfg_q),
    .wr_ok    (wr_ok),
    .bad_wr   (bad_wr),
    .zero_cnt (zero_cnt)
  );

  gt_tick_sel #(.NS(SRC_N)) u_sel (
    .strobes (tick_src),
    .sel     (cfg_q.src),
    .hold    (cfg_q.hold),
    .advance (advance)
  );

  gt_counter #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .clr     (soft_clr),
    .zero    (zero_cnt),
    .advance (advance),
    .restart (!cfg_q.mode),
    .tap     (cfg_q.tap),
    .cnt     (cnt_q),
    .expired (exp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= !rst_req && (bad_wr || (exp_q && !cfg_q.mode));
    end
  end

  always_ff @(posedge clk) begin
    if (soft_clr) begin
      irq_out <= 1'b0;
    end else if (exp_q && cfg_q.mode) begin
      irq_out <= 1'b1;
    end else if (irq_ack) begin
      irq_out <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (bus_addr == CTRL_ADDR) begin
        bus_rdata <= {KEY_READ, cfg_q.hold, cfg_q.src, cfg_q.mode, 1'b0, cfg_q.tap};
      end else begin
        bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter int                CW        = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_ack,
  input logic              irq_out,
  input logic              rst_req,
  input cfg_t              cfg,
  input logic [CW-1:0]     cnt,
  input logic              expired
);

  // R2
  read_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == CTRL_ADDR) |=> (bus_rdata[15:8] == KEY_READ && !bus_rdata[ZERO_BIT]));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == CTRL_ADDR && bus_be == 2'b11 &&
     bus_wdata[15:8] != KEY_WRITE && !rst_req) |=> rst_req);

  // R5
  half_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == CTRL_ADDR && $countones(bus_be) == 1 && !rst_req) |=> rst_req);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  soft_reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (cfg == CFG_RST && cnt == '0 && !irq_out));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.hold && !bus_we && !rst_req) |=> $stable(cnt));

  // R12
  watchdog_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !cfg.mode && !rst_req) |=> rst_req);

  // R13
  interval_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && cfg.mode && !rst_req) |=> irq_out);

  // R13
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !irq_ack && !rst_req) |=> irq_out);

  // R14
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !expired) |=> !irq_out);

endmodule

bind guard_timer guard_timer_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .CW        (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .bus_rdata (bus_rdata),
  .irq_ack   (irq_ack),
  .irq_out   (irq_out),
  .rst_req   (rst_req),
  .cfg       (cfg_q),
  .cnt       (cnt_q),
  .expired   (exp_q)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq_ack = 1'b0;
  logic        irq_out;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  guard_timer uut (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .tick_src  (tick_src),
    .irq_ack   (irq_ack),
    .irq_out   (irq_out),
    .rst_req   (rst_req)
  );

  always @(negedge clk) if (!rst && rst_req) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 0; bus_re = 0; tick_src = '0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic run_ticks(input logic [3:0] mask, input int n);
    if (n > 0) begin
      tick_src = mask;
      repeat (n) @(negedge clk);
      tick_src = '0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(4'd0, v);
    chk("R1 reset read", v, 16'h6904);
    chk("R1 rst_req low", rst_req, 0);
    chk("R1 irq low", irq_out, 0);
  endtask

  task automatic t_write_read();
    logic [15:0] v;
    int p;
    do_reset();
    p = pulses;
    wr(4'd0, 16'h5AB7, 2'b11);
    rd(4'd0, v);
    chk("R3 fields loaded, R2 bit3 reads 0", v, 16'h69B7);
    wr(4'd0, 16'h5A4A, 2'b11);
    rd(4'd0, v);
    chk("R3 second pattern", v, 16'h6942);
    chk("R3 no reset request", pulses - p, 0);
  endtask

  task automatic t_bad_key();
    logic [15:0] v;
    int p;
    do_reset();
    wr(4'd0, 16'h5A17, 2'b11);
    p = pulses;
    wr(4'd0, 16'h1297, 2'b11);
    repeat (2) @(negedge clk);
    chk("R4 wrong key pulse", pulses - p, 1);
    rd(4'd0, v);
    chk("R4 R7 fields back to reset", v, 16'h6904);
  endtask

  task automatic t_partial();
    logic [15:0] v;
    int p;
    do_reset();
    p = pulses;
    wr(4'd0, 16'h5A9F, 2'b10);
    repeat (2) @(negedge clk);
    chk("R5 upper lane only pulse", pulses - p, 1);
    wr(4'd0, 16'h5A9F, 2'b01);
    repeat (2) @(negedge clk);
    chk("R5 lower lane only pulse", pulses - p, 2);
    wr(4'd0, 16'h1234, 2'b00);
    repeat (2) @(negedge clk);
    chk("R5 no lane ignored", pulses - p, 2);
    rd(4'd0, v);
    chk("R5 register unchanged", v, 16'h6904);
  endtask

  task automatic t_other_addr();
    logic [15:0] v;
    int p;
    do_reset();
    p = pulses;
    wr(4'd3, 16'h1234, 2'b11);
    wr(4'd1, 16'h5A9F, 2'b11);
    repeat (2) @(negedge clk);
    chk("R6 no pulse", pulses - p, 0);
    rd(4'd0, v);
    chk("R6 ctrl unchanged", v, 16'h6904);
    rd(4'd1, v);
    chk("R2 other address reads 0", v, 16'h0000);
  endtask

  task automatic t_src_irq();
    int p;
    do_reset();
    p = pulses;
    wr(4'd0, 16'h5A5F, 2'b11);       // source 10, interval, clear, tap 111
    run_ticks(4'b1011, 100);
    chk("R8 other strobes ignored", irq_out, 0);
    run_ticks(4'b0100, 63);
    chk("R11 no expiry at 63", irq_out, 0);
    run_ticks(4'b0100, 1);
    chk("R13 R11 expiry at 64", irq_out, 1);
    repeat (5) @(negedge clk);
    chk("R13 flag sticky", irq_out, 1);
    chk("R13 no reset request", pulses - p, 0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    chk("R14 ack clears", irq_out, 0);
  endtask

  task automatic t_hold();
    do_reset();
    wr(4'd0, 16'h5A9F, 2'b11);       // hold, interval, clear, tap 111
    run_ticks(4'b0001, 100);
    chk("R9 held counter no expiry", irq_out, 0);
    wr(4'd0, 16'h5A17, 2'b11);       // release hold, keep count
    run_ticks(4'b0001, 63);
    chk("R9 count frozen, none at 63", irq_out, 0);
    run_ticks(4'b0001, 1);
    chk("R9 expiry at 64 after release", irq_out, 1);
  endtask

  task automatic t_clear();
    do_reset();
    wr(4'd0, 16'h5A1F, 2'b11);
    run_ticks(4'b0001, 40);
    wr(4'd0, 16'h5A1F, 2'b11);
    run_ticks(4'b0001, 63);
    chk("R10 cleared, none at 63", irq_out, 0);
    run_ticks(4'b0001, 1);
    chk("R10 expiry at 64 after clear", irq_out, 1);
  endtask

  task automatic t_running();
    do_reset();
    wr(4'd0, 16'h5A1E, 2'b11);       // interval, tap 110 -> bit 9
    run_ticks(4'b0001, 511);
    chk("R11 tap 110 none at 511", irq_out, 0);
    run_ticks(4'b0001, 1);
    chk("R11 tap 110 fires at 512", irq_out, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    run_ticks(4'b0001, 1023);
    chk("R13 counter keeps running", irq_out, 0);
    run_ticks(4'b0001, 1);
    chk("R13 second expiry at 1536", irq_out, 1);
  endtask

  task automatic t_wdog_fast();
    logic [15:0] v;
    int p;
    do_reset();
    wr(4'd0, 16'h5A6F, 2'b11);       // source 11, watchdog, clear, tap 111
    p = pulses;
    run_ticks(4'b1000, 63);
    chk("R12 none at 63", pulses - p, 0);
    run_ticks(4'b1000, 1);
    chk("R12 reset request at 64", pulses - p, 1);
    rd(4'd0, v);
    chk("R7 fields reset after expiry", v, 16'h6904);
  endtask

  task automatic t_wdog_default();
    int p;
    do_reset();
    p = pulses;
    run_ticks(4'b0001, 32767);
    chk("R11 default tap none at 32767", pulses - p, 0);
    run_ticks(4'b0001, 1);
    chk("R12 default tap fires at 32768", pulses - p, 1);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_bad_key();
    t_partial();
    t_other_addr();
    t_src_irq();
    t_hold();
    t_clear();
    t_running();
    t_wdog_fast();
    t_wdog_default();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule